// File: doc/BRIEF.md
# Converter Power-On Register Writer

This block brings a high-speed data converter into its working output mode without any help from software. When reset is released it steps through a short fixed list of register writes. Each write goes out as one serial frame on a three-wire link: an active-low select, a serial clock and one data pin. The data pin could carry data in both directions, but this block only drives it. An output-enable pin shows when the pin is being driven, so a pad ring can build the tristate buffer.

The list has two entries, and their order matters. The first entry writes the output-format register at address 0x014. It selects differential low-swing output with offset-binary coding, and its value is a parameter. The second entry writes 0x01 to the transfer register at address 0x0FF. The format setting only takes effect once that commit write has been made.

The serial clock comes from the system clock through a divider. With a 200 MHz system clock, the default half-period of 4 cycles gives 25 MHz. Each instance serves one converter, so a board with two converters uses two instances. Both are control pins: `busy` is high while the list is running, and `done` is high once the list has finished.

Top module: `adcfg_spi_init`

## Requirements
- R1: While reset is asserted, and from then on until the first frame starts, `spi_csn` is 1, `spi_sclk` is 0 and `spi_sdio_oe` is 0. While reset is asserted, `busy` and `done` are both 0.
- R2: Each frame is 24 bits, sent most significant bit first. Bit 23 is the direction bit and is 0 for a write. Bits 22:21 give the word length, and 00 means one byte. Bits 20:8 hold the 13-bit register address and bits 7:0 hold the data byte.
- R3: The first frame after reset writes address 0x014 with the value of `FMT_VALUE` (default 0x40), so it is 24'h001440 by default.
- R4: The second frame writes 0x01 to address 0x0FF (24'h00FF01). After it, no further frame is sent until the next reset.
- R5: `spi_csn` stays low for a whole frame and sees exactly 24 rising edges of `spi_sclk`. `spi_sclk` is 0 whenever `spi_csn` is high, and it is also 0 in the cycle in which `spi_csn` falls.
- R6: Inside a frame, `spi_sdio` changes only while `spi_sclk` is low. It holds its value for as long as `spi_sclk` is high.
- R7: The high and low phases of `spi_sclk` each last `HALF_DIV` system clocks. Successive rising edges are therefore 2*`HALF_DIV` cycles apart.
- R8: Between the end of one frame and the start of the next, `spi_csn` stays high for at least `GAP_CYCLES` system clocks.
- R9: `busy` is 1 from the first cycle after reset until the last frame has ended. Then `done` goes to 1 and `busy` returns to 0, and `done` stays 1 until the next reset. The two are never high together.
- R10: `spi_sdio_oe` is 1 exactly while `spi_csn` is low.
- R11: If reset is asserted in the middle of a frame, the outputs return to their R1 values at once. After reset is released, the list runs again from its first entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_csn | output | 1 | Serial select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_sdio | output | 1 | Serial data, changes while the clock is low |
| spi_sdio_oe | output | 1 | Drive enable for the data pin |
| busy | output | 1 | Write list in progress |
| done | output | 1 | Write list finished, held until reset |

## Verification
The bench rebuilds each frame from the rising clock edges it sees and compares it with a queue of expected words. A design that reversed the table order, or sent the commit write before the format write, would fail in the first slot. A design that kept repeating the list would run into an empty queue. The timing checks look at the gap between the two frames and at the length of each clock phase. They also check that data never moves while the clock is high, which catches a design that shifts on the wrong edge or merges the inter-frame gap away. A reset is also applied mid-frame: a design that resumed at the second entry, or kept the select low through the reset, would show a wrong first word or a truncated frame.

// File: rtl/adcfg_pkg.sv
package adcfg_pkg;
  localparam int FRAME_W = 24;
  localparam int ADDR_W  = 13;
  localparam int DATA_W  = 8;

  localparam logic              DIR_WRITE   = 1'b0;
  localparam logic [1:0]        WLEN_ONE    = 2'b00;
  localparam logic [ADDR_W-1:0] ADDR_FORMAT = 13'h014;
  localparam logic [ADDR_W-1:0] ADDR_COMMIT = 13'h0FF;
  localparam logic [DATA_W-1:0] COMMIT_VAL  = 8'h01;

  typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH, E_TAIL} eng_state_t;
  typedef enum logic [2:0] {S_BOOT, S_ISSUE, S_WAIT, S_GAP, S_FIN} seq_state_t;

  function automatic logic [FRAME_W-1:0] make_frame(input logic [ADDR_W-1:0] a,
                                                    input logic [DATA_W-1:0] d);
    return {DIR_WRITE, WLEN_ONE, a, d};
  endfunction
endpackage

// File: rtl/adcfg_sclk_div.sv
module adcfg_sclk_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run || cnt == LAST) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/adcfg_spi_wr.sv
module adcfg_spi_wr
  import adcfg_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               csn,
  output logic               sclk,
  output logic               sdo,
  output logic               sdo_oe,
  output logic               frame_done
);
  localparam int BW = $clog2(FRAME_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  eng_state_t         st;
  logic [FRAME_W-1:0] shreg;
  logic [BW-1:0]      bit_cnt;
  logic               tick;

  adcfg_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st != E_IDLE),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= E_IDLE;
      csn        <= 1'b1;
      sclk       <= 1'b0;
      sdo        <= 1'b0;
      sdo_oe     <= 1'b0;
      shreg      <= '0;
      bit_cnt    <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (st)
        E_IDLE: if (start) begin
          csn     <= 1'b0;
          sdo_oe  <= 1'b1;
          sdo     <= frame[FRAME_W-1];
          shreg   <= {frame[FRAME_W-2:0], 1'b0};
          bit_cnt <= '0;
          st      <= E_LOW;
        end
        E_LOW: if (tick) begin
          sclk <= 1'b1;
          st   <= E_HIGH;
        end
        E_HIGH: if (tick) begin
          sclk <= 1'b0;
          if (bit_cnt == LAST_BIT) begin
            st <= E_TAIL;
          end else begin
            sdo     <= shreg[FRAME_W-1];
            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
            st      <= E_LOW;
          end
        end
        E_TAIL: if (tick) begin
          csn        <= 1'b1;
          sdo_oe     <= 1'b0;
          sdo        <= 1'b0;
          frame_done <= 1'b1;
          st         <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adcfg_seq.sv
module adcfg_seq
  import adcfg_pkg::*;
#(
  parameter int          GAP_CYCLES = 4,
  parameter logic [7:0]  FMT_VALUE  = 8'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  output logic               start,
  output logic [FRAME_W-1:0] frame,
  output logic               busy,
  output logic               done
);
  localparam int NUM_ENTRIES = 2;
  localparam int IW = $clog2(NUM_ENTRIES);
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_ENTRIES - 1);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

  seq_state_t    st;
  logic [IW-1:0] idx;
  logic [GW-1:0] gap_cnt;

  // Table order is behaviour: the format write must precede the commit write.
  always_comb begin
    case (idx)
      IW'(0):  frame = make_frame(ADDR_FORMAT, FMT_VALUE);
      default: frame = make_frame(ADDR_COMMIT, COMMIT_VAL);
    endcase
  end

  assign start = (st == S_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_BOOT;
      idx     <= '0;
      gap_cnt <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      case (st)
        S_BOOT: begin
          busy <= 1'b1;
          st   <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (frame_done) begin
          if (idx == LAST_IDX) begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= S_FIN;
          end else begin
            idx     <= idx + 1'b1;
            gap_cnt <= '0;
            st      <= S_GAP;
          end
        end
        S_GAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == GAP_LAST) st <= S_ISSUE;
        end
        S_FIN:   st <= S_FIN;
        default: st <= S_BOOT;
      endcase
    end
  end
endmodule

// File: rtl/adcfg_spi_init.sv
module adcfg_spi_init
  import adcfg_pkg::*;
#(
  parameter int         HALF_DIV   = 4,
  parameter int         GAP_CYCLES = 4,
  parameter logic [7:0] FMT_VALUE  = 8'h40
) (
  input  logic clk,
  input  logic rst_n,
  output logic spi_csn,
  output logic spi_sclk,
  output logic spi_sdio,
  output logic spi_sdio_oe,
  output logic busy,
  output logic done
);
  logic               start;
  logic               frame_done;
  logic [FRAME_W-1:0] frame;

  adcfg_seq #(.GAP_CYCLES(GAP_CYCLES), .FMT_VALUE(FMT_VALUE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_done(frame_done),
    .start     (start),
    .frame     (frame),
    .busy      (busy),
    .done      (done)
  );

  adcfg_spi_wr #(.HALF_DIV(HALF_DIV)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .frame     (frame),
    .csn       (spi_csn),
    .sclk      (spi_sclk),
    .sdo       (spi_sdio),
    .sdo_oe    (spi_sdio_oe),
    .frame_done(frame_done)
  );
endmodule

// File: rtl/adcfg_spi_init_chk.sv
module adcfg_spi_init_chk #(
  parameter int GAP_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic spi_csn,
  input logic spi_sclk,
  input logic spi_sdio,
  input logic spi_sdio_oe,
  input logic busy,
  input logic done
);
  logic [15:0] hi_cnt;
  logic        seen;
  logic        csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      seen   <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      csn_d <= spi_csn;
      if (spi_csn && !csn_d) seen <= 1'b1;
      if (!spi_csn)              hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_sclk);  // R5
  AST_CS_FALL_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_csn) |-> !spi_sclk);  // R5
  AST_SDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_csn && spi_sclk && $past(spi_sclk)) |-> $stable(spi_sdio));  // R6
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $fell(spi_csn)) |-> (hi_cnt >= 16'(GAP_CYCLES)));  // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);  // R9
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));  // R9
  AST_OE_MATCHES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sdio_oe == !spi_csn);  // R10
endmodule

bind adcfg_spi_init adcfg_spi_init_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_csn    (spi_csn),
  .spi_sclk   (spi_sclk),
  .spi_sdio   (spi_sdio),
  .spi_sdio_oe(spi_sdio_oe),
  .busy       (busy),
  .done       (done)
);

// File: tb/adcfg_spi_init_tb.sv
module adcfg_spi_init_tb;
  localparam int HALF = 4;
  localparam int GAP  = 4;
  localparam logic [7:0] FMT = 8'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn, sclk, sdio, oe, busy, done;

  always #2.5 clk = ~clk;

  adcfg_spi_init #(.HALF_DIV(HALF), .GAP_CYCLES(GAP), .FMT_VALUE(FMT)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sclk(sclk), .spi_sdio(sdio),
    .spi_sdio_oe(oe), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor state
  logic        p_csn = 1'b1, p_sclk = 1'b0, p_sdio = 1'b0;
  logic [23:0] word = '0;
  int bits = 0, frames = 0, hi_cnt = 0, cyc = 0, last_rise = 0, hi_len = 0;
  bit v_sdio = 0, v_oe = 0, v_per = 0, v_hi = 0, v_idle = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      p_csn = 1'b1; p_sclk = 1'b0; p_sdio = 1'b0;
      bits = 0; frames = 0; hi_cnt = 0; word = '0;
    end else begin
      if (p_csn && !csn) begin
        if (frames > 0) chk(hi_cnt >= GAP, "R8", "select high gap", hi_cnt, GAP);
        chk(busy === 1'b1, "R9", "busy at frame start", busy, 1);
        chk(sclk === 1'b0, "R5", "sclk at select fall", sclk, 0);
        bits = 0; word = '0; v_sdio = 0; v_oe = 0; v_per = 0; v_hi = 0; hi_len = 0;
      end
      if (!csn) begin
        if (oe !== 1'b1) v_oe = 1;
        if (sclk && p_sclk && sdio !== p_sdio) v_sdio = 1;
        if (sclk) hi_len++;
        if (!sclk && p_sclk && hi_len != HALF) v_hi = 1;
        if (!sclk) hi_len = 0;
        if (sclk && !p_sclk) begin
          word = {word[22:0], sdio};
          if (bits > 0 && (cyc - last_rise) != 2 * HALF) v_per = 1;
          last_rise = cyc;
          bits++;
        end
        hi_cnt = 0;
      end else begin
        hi_cnt++;
        if (sclk !== 1'b0 || oe !== 1'b0) v_idle = 1;
      end
      if (!p_csn && csn) begin
        chk(bits == 24, "R5", "clock edges per frame", bits, 24);
        chk(!v_sdio, "R6", "data moved while clock high", v_sdio, 0);
        chk(!v_oe, "R10", "oe low inside frame", v_oe, 0);
        chk(!v_per && !v_hi, "R7", "clock phase length", {v_per, v_hi}, 0);
        chk(word[23:21] == 3'b000, "R2", "direction/length bits", word[23:21], 0);
        if (exp_q.size() == 0) begin
          chk(0, "R4", "unexpected extra frame", word, 0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk(word == e, (frames == 0) ? "R3" : "R4", "frame word", word, e);
        end
        frames++;
      end
      p_csn = csn; p_sclk = sclk; p_sdio = sdio;
    end
  end

  task automatic push_list();
    exp_q.delete();
    exp_q.push_back({1'b0, 2'b00, 13'h014, FMT});
    exp_q.push_back({1'b0, 2'b00, 13'h0FF, 8'h01});
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    summary();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(csn === 1'b1, "R1", "csn in reset", csn, 1);
    chk(sclk === 1'b0, "R1", "sclk in reset", sclk, 0);
    chk(oe === 1'b0, "R1", "oe in reset", oe, 0);
    chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
    push_list();
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(busy === 1'b1, "R9", "busy after reset", busy, 1);
    while (done !== 1'b1) @(negedge clk);
    chk(busy === 1'b0, "R9", "busy after done", busy, 0);
    chk(exp_q.size() == 0 && frames == 2, "R4", "frames sent", frames, 2);
    repeat (300) @(negedge clk);
    chk(done === 1'b1 && csn === 1'b1, "R9", "done held, link idle", {done, csn}, 2'b11);
    chk(frames == 2, "R4", "no frame after list", frames, 2);
    chk(!v_idle, "R5", "clock or oe active while idle", v_idle, 0);

    // Mid-frame reset
    @(posedge clk); #1 rst_n = 1'b0;
    push_list();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    while (!(bits >= 10 && csn === 1'b0)) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b0;
    #1;
    chk(csn === 1'b1 && sclk === 1'b0 && oe === 1'b0, "R11", "async return to idle",
        {csn, sclk, oe}, 3'b100);
    chk(busy === 1'b0 && done === 1'b0, "R11", "status cleared", {busy, done}, 0);
    push_list();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    while (done !== 1'b1) @(negedge clk);
    chk(exp_q.size() == 0 && frames == 2, "R11", "list rerun from first entry", frames, 2);
    summary();
  end
endmodule